// File: doc/BRIEF.md
# Timed Asynchronous SRAM Controller

This block sits between a clocked host and an external asynchronous byte-wide static memory. The host issues one read or one write at a time. The block then drives the memory's address, its two chip selects (one active low, one active high), its write strobe and its output enable. It also controls a byte-wide data output with its own drive enable. Each phase of an access is held for a whole number of clock cycles. That number is derived from the memory's nanosecond minimums and a clock-period parameter.

A read keeps the chip selected with output enable active until the address access time has passed. It samples the returned byte into a holding register. It then idles the memory for enough cycles to cover the time the memory takes to release the data bus. A write selects the chip and drives the data with output enable held off. It then pulses the write strobe and ends with a short recovery in which the address and data stay put. The host sees a single-cycle completion pulse after each access.

Top module: `sram_timed_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, mem_ce1_n=1, mem_ce2=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, host_done=0 and host_rdata=0.
- R2: A read keeps mem_ce1_n=0, mem_ce2=1, mem_oe_n=0 and mem_we_n=1 for exactly max(ceil(55/P), ceil(25/P)) cycles, where P is CLK_PERIOD_NS (7 cycles at 8 ns). host_rdata takes the value of mem_dq_in at the end of the last of those cycles and shows it from the next cycle.
- R3: host_rdata changes only when a read completes its sampling phase. Writes and idle cycles leave it unchanged.
- R4: After the read phase, all memory strobes are inactive and mem_dq_oe=0 for ceil(20/P) cycles (3 at 8 ns) before completion. The data drivers are never enabled fewer than that many cycles after output enable goes inactive.
- R5: A write consists of three phases with mem_ce1_n=0, mem_ce2=1 and mem_dq_oe=1 throughout. The first is a setup phase with mem_we_n=1 lasting max(1, ceil(50/P)-W) cycles. The second is a strobe phase with mem_we_n=0 lasting W = max(ceil(45/P), ceil(25/P)) cycles. The third is a recovery phase with mem_we_n=1 lasting max(1, ceil(55/P)-setup-W) cycles. At 8 ns these are 1, 6 and 1 cycles.
- R6: mem_oe_n is never 0 while mem_we_n=0 or mem_dq_oe=1.
- R7: host_done is high for exactly one cycle, the first idle cycle after each access. host_req is sampled only in idle cycles, including that one, and is ignored at every other time.
- R8: mem_addr and mem_dq_out carry the address and data captured when the request was accepted. Changes on the host inputs during the access have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request, sampled in idle cycles |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_wdata | input | DATA_W | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Last byte read, held |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from memory |

## Verification
The assertions check several properties on every cycle. Output enable must never overlap the write strobe or the data drivers. The write strobe may be active only while the chip is selected and driven. Address and data must stay still across the strobe and the cycle that follows it. The strobe and the read window must meet their minimum lengths, and the bus turnaround before driving must be long enough. host_rdata may move only right after a read, and the completion pulse must last one cycle. The exact phase lengths, the value actually sampled, and the rejection of requests while busy are shown only by the bench's scenarios. There, a memory model returns valid data only after the access time and latches data only at the end of a strobe, and a cycle-by-cycle reference predicts every strobe and host output.

// File: rtl/sram_timed_ctrl.sv
module sram_timed_ctrl #(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 55,
  parameter int T_OE_NS       = 25,
  parameter int T_WP_NS       = 45,
  parameter int T_DW_NS       = 25,
  parameter int T_AW_NS       = 50,
  parameter int T_WC_NS       = 55,
  parameter int T_REL_NS      = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int N_RD   = (cyc(T_RC_NS) > cyc(T_OE_NS)) ? cyc(T_RC_NS) : cyc(T_OE_NS);
  localparam int N_TURN = cyc(T_REL_NS);
  localparam int N_WP   = (cyc(T_WP_NS) > cyc(T_DW_NS)) ? cyc(T_WP_NS) : cyc(T_DW_NS);
  localparam int N_WSU  = (cyc(T_AW_NS) > N_WP + 1) ? cyc(T_AW_NS) - N_WP : 1;
  localparam int N_WREC = (cyc(T_WC_NS) > N_WSU + N_WP + 1) ? cyc(T_WC_NS) - N_WSU - N_WP : 1;
  localparam int N_MAX  = (N_RD > N_WP) ? ((N_RD > N_WSU) ? N_RD : N_WSU)
                                        : ((N_WP > N_WSU) ? N_WP : N_WSU);
  localparam int N_MAX2 = (N_MAX > N_TURN) ? ((N_MAX > N_WREC) ? N_MAX : N_WREC)
                                           : ((N_TURN > N_WREC) ? N_TURN : N_WREC);
  localparam int CNT_W  = $clog2(N_MAX2 + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_TURN, S_WSU, S_WP, S_WREC} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              last;
  logic              sel;

  assign last = (cnt == '0);
  assign sel  = (st == S_RD) || (st == S_WSU) || (st == S_WP) || (st == S_WREC);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
      host_done  <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (host_req) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
            if (host_wr) begin
              st  <= S_WSU;
              cnt <= CNT_W'(N_WSU - 1);
            end else begin
              st  <= S_RD;
              cnt <= CNT_W'(N_RD - 1);
            end
          end
        end
        S_RD: begin
          if (last) begin
            host_rdata <= mem_dq_in;
            st         <= S_TURN;
            cnt        <= CNT_W'(N_TURN - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TURN: begin
          if (last) begin
            st        <= S_IDLE;
            host_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WSU: begin
          if (last) begin
            st  <= S_WP;
            cnt <= CNT_W'(N_WP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WP: begin
          if (last) begin
            st  <= S_WREC;
            cnt <= CNT_W'(N_WREC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WREC: begin
          if (last) begin
            st        <= S_IDLE;
            host_done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce1_n  = !sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = (st != S_WP);
  assign mem_oe_n   = (st != S_RD);
  assign mem_dq_oe  = (st == S_WSU) || (st == S_WP) || (st == S_WREC);

endmodule

module sram_timed_ctrl_chk #(
  parameter int CLK_PERIOD_NS = 8,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              host_done,
  input logic [DATA_W-1:0] host_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  localparam int C_RD   = (55 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_WP   = (45 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int C_TURN = (20 + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;

  logic [7:0] we_len, oe_len, off_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_len  <= '0;
      oe_len  <= '0;
      off_len <= 8'hff;
    end else begin
      we_len  <= !mem_we_n ? ((we_len == 8'hff) ? we_len : we_len + 1'b1) : 8'h0;
      oe_len  <= !mem_oe_n ? ((oe_len == 8'hff) ? oe_len : oe_len + 1'b1) : 8'h0;
      off_len <=  mem_oe_n ? ((off_len == 8'hff) ? off_len : off_len + 1'b1) : 8'h0;
    end
  end

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe)); // R6
  AST_WE_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe)); // R5
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n || $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R8
  AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_len >= 8'(C_WP))); // R5
  AST_READ_MIN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (oe_len >= 8'(C_RD))); // R2
  AST_BUS_TURNAROUND: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (off_len >= 8'(C_TURN))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done); // R7
  AST_RDATA_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    !$stable(host_rdata) |-> $past(!mem_oe_n)); // R3
endmodule

bind sram_timed_ctrl sram_timed_ctrl_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .host_done(host_done), .host_rdata(host_rdata),
  .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
  .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sram_timed_ctrl.sv
module tb_sram_timed_ctrl;
  localparam int P     = 8;
  localparam int RD_N  = ((55 + P - 1) / P > (25 + P - 1) / P) ? (55 + P - 1) / P : (25 + P - 1) / P;
  localparam int ACC_N = (55 + P - 1) / P;
  localparam int TRN_N = (20 + P - 1) / P;
  localparam int WP_N  = ((45 + P - 1) / P > (25 + P - 1) / P) ? (45 + P - 1) / P : (25 + P - 1) / P;
  localparam int SU_N  = ((50 + P - 1) / P - WP_N > 1) ? (50 + P - 1) / P - WP_N : 1;
  localparam int REC_N = ((55 + P - 1) / P - SU_N - WP_N > 1) ? (55 + P - 1) / P - SU_N - WP_N : 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [16:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_done;
  logic [7:0]  host_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  bus_drv = 8'hEE;

  sram_timed_ctrl dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_done(host_done),
    .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(bus_drv)
  );

  typedef struct packed {
    logic ce1_n, ce2, we_n, oe_n, dq_oe, done;
    logic [16:0] addr;
    logic [7:0]  dout, rdata;
  } vec_t;

  vec_t q[$];
  int compared = 0, mismatched = 0, cycles = 0;
  bit finished = 0, done_next = 0;
  logic [7:0] m_rdata = 8'h00;
  logic [7:0] model_mem[int];
  logic [7:0] store[int];

  function automatic logic [7:0] dflt(input int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic cmp(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // R1 reset state observed before the reference takes over
  task automatic check_reset();
    cmp("R1", "ce1_n", mem_ce1_n, 1);
    cmp("R1", "ce2", mem_ce2, 0);
    cmp("R1", "we_n", mem_we_n, 1);
    cmp("R1", "oe_n", mem_oe_n, 1);
    cmp("R1", "dq_oe", mem_dq_oe, 0);
    cmp("R1", "done", host_done, 0);
    cmp("R1", "rdata", host_rdata, 0);
  endtask

  function automatic vec_t mk(input logic sel, input logic we_n, input logic oe_n,
                              input logic dq_oe, input logic [16:0] a,
                              input logic [7:0] d, input logic [7:0] rd);
    vec_t v;
    v.ce1_n = !sel; v.ce2 = sel; v.we_n = we_n; v.oe_n = oe_n;
    v.dq_oe = dq_oe; v.done = 1'b0; v.addr = a; v.dout = d; v.rdata = rd;
    return v;
  endfunction

  // reference model: predicts every cycle, compares at the falling edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      vec_t e;
      bit idle;
      logic [7:0] v;
      idle = (q.size() == 0);
      if (idle) begin
        e = mk(1'b0, 1'b1, 1'b1, 1'b0, '0, '0, m_rdata);
        e.done = done_next;
      end else begin
        e = q.pop_front();
      end
      cmp("R2/R5", "ce1_n", mem_ce1_n, e.ce1_n);
      cmp("R2/R5", "ce2", mem_ce2, e.ce2);
      cmp("R5", "we_n", mem_we_n, e.we_n);
      cmp("R2/R4/R6", "oe_n", mem_oe_n, e.oe_n);
      cmp("R4/R5/R6", "dq_oe", mem_dq_oe, e.dq_oe);
      cmp("R7", "done", host_done, e.done);
      cmp("R2/R3", "rdata", host_rdata, e.rdata);
      if (!e.ce1_n) cmp("R8", "addr", mem_addr, e.addr);
      if (e.dq_oe)  cmp("R8", "dout", mem_dq_out, e.dout);
      done_next = (!idle && q.size() == 0);
      // R7: a request counts only in an idle cycle
      if (idle && host_req) begin
        if (host_wr) begin
          for (int i = 0; i < SU_N; i++)  q.push_back(mk(1, 1, 1, 1, host_addr, host_wdata, m_rdata));
          for (int i = 0; i < WP_N; i++)  q.push_back(mk(1, 0, 1, 1, host_addr, host_wdata, m_rdata));
          for (int i = 0; i < REC_N; i++) q.push_back(mk(1, 1, 1, 1, host_addr, host_wdata, m_rdata));
          model_mem[int'(host_addr)] = host_wdata;
        end else begin
          v = model_mem.exists(int'(host_addr)) ? model_mem[int'(host_addr)] : dflt(int'(host_addr));
          for (int i = 0; i < RD_N; i++)  q.push_back(mk(1, 1, 0, 0, host_addr, '0, m_rdata));
          for (int i = 0; i < TRN_N; i++) q.push_back(mk(0, 1, 1, 0, '0, '0, v));
          m_rdata = v;
        end
      end
    end
  end

  // memory model: data valid only after the access time, latch at strobe end
  int rd_run = 0;
  logic [16:0] last_addr = '0;
  logic prev_we = 1'b1;
  always @(negedge clk) begin
    bit sel;
    sel = !mem_ce1_n && mem_ce2;
    if (sel && !mem_oe_n && mem_we_n)
      rd_run = (rd_run > 0 && mem_addr == last_addr) ? rd_run + 1 : 1;
    else
      rd_run = 0;
    last_addr = mem_addr;
    if (rd_run >= ACC_N)
      bus_drv = store.exists(int'(mem_addr)) ? store[int'(mem_addr)] : dflt(int'(mem_addr));
    else
      bus_drv = 8'hEE;
    if (!prev_we && mem_we_n && sel && mem_dq_oe)
      store[int'(mem_addr)] = mem_dq_out;
    prev_we = mem_we_n;
  end

  task automatic txn(input logic wr, input logic [16:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_req = 1'b0; host_wr = !wr; host_addr = ~a; host_wdata = ~d;  // R8 scramble
    @(negedge clk);
    while (!host_done) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      check_reset();  // R1
    end
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check_reset();    // R1 first cycle out of reset
    // R2 R5 edge addresses and data values
    txn(1'b1, 17'h00000, 8'hA5);
    txn(1'b0, 17'h00000, 8'h00);
    txn(1'b1, 17'h1FFFF, 8'hFF);
    txn(1'b0, 17'h1FFFF, 8'h00);
    txn(1'b1, 17'h00005, 8'h00);
    // R3 a write after a read leaves the read data in place
    txn(1'b0, 17'h00123, 8'h00);
    txn(1'b1, 17'h00123, 8'h3C);
    txn(1'b0, 17'h00005, 8'h77);
    txn(1'b0, 17'h00123, 8'h00);
    // R7 request held high: back-to-back accepts, nothing taken while busy
    @(posedge clk); #1;
    host_req = 1'b1; host_wr = 1'b1; host_addr = 17'h00040; host_wdata = 8'h5E;
    repeat (25) @(posedge clk);
    #1 host_wr = 1'b0;
    repeat (25) @(posedge clk);
    #1 host_req = 1'b0;
    repeat (20) @(posedge clk);
    // R4 R6 R8 mixed traffic with inputs changing every cycle
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      host_req   = ($urandom % 3) == 0;
      host_wr    = $urandom % 2;
      case ($urandom % 4)
        0: host_addr = 17'h00000;
        1: host_addr = 17'h1FFFF;
        default: host_addr = 17'($urandom % 12);
      endcase
      host_wdata = 8'($urandom);
    end
    #1 host_req = 1'b0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule